// File: doc/BRIEF.md
# Retention Latch Result Cache

This block is a small, fully associative store of recently produced results. Each entry is tagged with the physical register index of the instruction that produced the value. Dispatch logic probes it through one or two lookup ports to fetch source operands. Without it, such an operand would have to wait until the value is forwarded at commit. Writes come from the writeback result bus.

Each written result carries a short-lived flag, computed upstream. The flag is set when the destination has already been renamed again before the result is produced. A flagged value is never read from this store later, so it is dropped instead of being allocated. This keeps the few entries free for values that can still be hit.

Replacement is fixed at build time by a parameter: FIFO (oldest allocation goes first) or LRU (least recently touched goes first). A flush input empties the store in one cycle. The lookup and write interfaces carry a valid strobe only. The store accepts every beat in the cycle it is presented and never applies back-pressure, so there is no ready signal.

Top module: `rl_cache`

## Requirements
- R1: A lookup with `lk_valid[p]` high whose tag equals the tag of a valid entry returns `rsp_valid[p]=1`, `rsp_hit[p]=1` and that entry's data on the next cycle; `rsp_valid[p]` is high exactly one cycle after each lookup and low otherwise.
- R2: A lookup whose tag matches no valid entry returns `rsp_hit[p]=0` with `rsp_data` slice equal to zero.
- R3: A write with `wr_valid=1` and `wr_short=0` (and no flush) is stored at the clock edge and is seen by lookups presented from the next cycle on; a lookup in the same cycle as the write sees the contents from before the write.
- R4: A write with `wr_short=1` leaves every entry's valid bit, tag and data unchanged.
- R5: A stored write whose tag already sits in a valid entry overwrites that entry's data in place, so no other entry is displaced and no tag is ever held twice.
- R6: With `POLICY=RL_FIFO`, an allocation takes the lowest-indexed empty entry if one exists; otherwise it replaces the entry allocated longest ago. In-place updates and lookups do not change this order.
- R7: With `POLICY=RL_LRU`, an allocation takes the lowest-indexed empty entry if one exists; otherwise it replaces the least recently touched entry. The choice is made on recency as it stood before the cycle's touches. Lookup hits and stored writes touch an entry.
- R8: `flush=1` invalidates all entries at the clock edge and drops a write presented in the same cycle; lookups in the flush cycle still answer from the old contents.
- R9: Both lookup ports work independently in the same cycle. Within one cycle, recency updates apply in the order port 0 hit, port 1 hit, then the write.
- R10: While `rst_n` is low and after it rises, the store is empty and `rsp_valid`, `rsp_hit` and `rsp_data` are zero until a lookup arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate every entry |
| wr_valid | input | 1 | Result bus beat present |
| wr_short | input | 1 | Result is short-lived; do not store |
| wr_tag | input | TAG_W | Producer register index of the result |
| wr_data | input | DATA_W | Result value |
| lk_valid | input | RD_PORTS | Lookup strobe per port |
| lk_tag | input | RD_PORTS*TAG_W | Requested tag per port, port p in bits [p*TAG_W +: TAG_W] |
| rsp_valid | output | RD_PORTS | Response present per port |
| rsp_hit | output | RD_PORTS | Tag found per port |
| rsp_data | output | RD_PORTS*DATA_W | Data per port, port p in bits [p*DATA_W +: DATA_W], zero on miss |

## Verification
A lookup is answered exactly one clock edge after it is presented. A stored write becomes visible to lookups made one cycle after it. A flush shows as misses for lookups made in the cycle after it. The bench drives inputs just after each falling edge and advances its queue-based model of both replacement policies at that moment. It compares the registered responses at the next falling edge, so each comparison lands on the cycle the response is due. Directed phases fill, hit, miss, drop short-lived results, update in place, evict under both policies and flush, and a long mixed phase exercises both ports together.

// File: rtl/rl_pkg.sv
package rl_pkg;
  typedef enum logic {
    RL_FIFO = 1'b0,
    RL_LRU  = 1'b1
  } rl_policy_e;
endpackage

// File: rtl/rl_read_port.sv
// Associative tag match over all entries with a one-hot data select.
module rl_read_port #(
  parameter int N      = 8,
  parameter int TAG_W  = 7,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]             ent_valid,
  input  logic [N-1:0][TAG_W-1:0]  ent_tag,
  input  logic [N-1:0][DATA_W-1:0] ent_data,
  input  logic [TAG_W-1:0]         req_tag,
  output logic [N-1:0]             match,
  output logic                     hit,
  output logic [IDX_W-1:0]         idx,
  output logic [DATA_W-1:0]        data
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match[i] = ent_valid[i] && (ent_tag[i] == req_tag);
  end

  assign hit = |match;

  always_comb begin
    idx  = '0;
    data = '0;
    for (int i = 0; i < N; i++) begin
      if (match[i]) begin
        idx  = IDX_W'(i);
        data = data | ent_data[i];
      end
    end
  end
endmodule

// File: rtl/rl_repl.sv
// Victim selection and recency state; the policy picks the variant.
module rl_repl #(
  parameter int N        = 8,
  parameter int RD_PORTS = 2,
  parameter rl_pkg::rl_policy_e POLICY = rl_pkg::RL_LRU,
  localparam int IDX_W = $clog2(N)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               flush,
  input  logic [N-1:0]                       ent_valid,
  input  logic [RD_PORTS-1:0]                rd_en,
  input  logic [RD_PORTS-1:0][IDX_W-1:0]     rd_idx,
  input  logic                               wr_en,
  input  logic [IDX_W-1:0]                   wr_idx,
  input  logic                               alloc,
  output logic [IDX_W-1:0]                   victim
);
  typedef logic [N-1:0][IDX_W-1:0] rank_t;

  // Move entry k to rank 0; every entry younger than it ages by one.
  function automatic rank_t promote(rank_t r, logic [IDX_W-1:0] k);
    rank_t o;
    o = r;
    for (int j = 0; j < N; j++) begin
      if (r[j] < r[k]) o[j] = r[j] + 1'b1;
    end
    o[k] = '0;
    return o;
  endfunction

  // Lowest-indexed empty slot.
  logic             has_free;
  logic [IDX_W-1:0] free_idx;
  always_comb begin
    has_free = 1'b0;
    free_idx = '0;
    for (int j = N - 1; j >= 0; j--) begin
      if (!ent_valid[j]) begin
        has_free = 1'b1;
        free_idx = IDX_W'(j);
      end
    end
  end

  if (POLICY == rl_pkg::RL_LRU) begin : g_lru
    rank_t            rank_q, rank_d;
    logic [IDX_W-1:0] oldest;
    logic             unused_lru;
    assign unused_lru = flush ^ alloc;

    always_comb begin
      rank_d = rank_q;
      for (int p = 0; p < RD_PORTS; p++) begin
        if (rd_en[p]) rank_d = promote(rank_d, rd_idx[p]);
      end
      if (wr_en) rank_d = promote(rank_d, wr_idx);
    end

    always_comb begin
      oldest = '0;
      for (int j = 0; j < N; j++) begin
        if (rank_q[j] == IDX_W'(N - 1)) oldest = IDX_W'(j);
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int j = 0; j < N; j++) rank_q[j] <= IDX_W'(j);
      end else begin
        rank_q <= rank_d;
      end
    end

    assign victim = has_free ? free_idx : oldest;
  end else begin : g_fifo
    logic [IDX_W-1:0] ptr_q;
    logic             unused_fifo;
    assign unused_fifo = ^{rd_en, rd_idx, wr_en, wr_idx, has_free, free_idx};

    always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
        ptr_q <= '0;
      end else if (alloc) begin
        ptr_q <= (ptr_q == IDX_W'(N - 1)) ? '0 : ptr_q + 1'b1;
      end
    end

    // Slots fill in index order and only a flush empties them, so the
    // pointer names the first empty slot or else the oldest allocation.
    assign victim = ptr_q;
  end
endmodule

// File: rtl/rl_cache.sv
module rl_cache #(
  parameter int ENTRIES  = 8,
  parameter int TAG_W    = 7,
  parameter int DATA_W   = 32,
  parameter int RD_PORTS = 2,
  parameter rl_pkg::rl_policy_e POLICY = rl_pkg::RL_LRU
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         wr_valid,
  input  logic                         wr_short,
  input  logic [TAG_W-1:0]             wr_tag,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic [RD_PORTS-1:0]          lk_valid,
  input  logic [RD_PORTS*TAG_W-1:0]    lk_tag,
  output logic [RD_PORTS-1:0]          rsp_valid,
  output logic [RD_PORTS-1:0]          rsp_hit,
  output logic [RD_PORTS*DATA_W-1:0]   rsp_data
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0][TAG_W-1:0]  tag_q;
  logic [ENTRIES-1:0][DATA_W-1:0] data_q;

  // Write side: find an existing copy of the tag, else take the victim.
  logic [ENTRIES-1:0] wr_match;
  logic               wr_hit;
  logic [IDX_W-1:0]   wr_hit_idx, victim, tgt;
  logic [DATA_W-1:0]  unused_wr_data;
  logic               store;

  rl_read_port #(.N(ENTRIES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_wr_probe (
    .ent_valid (valid_q),
    .ent_tag   (tag_q),
    .ent_data  (data_q),
    .req_tag   (wr_tag),
    .match     (wr_match),
    .hit       (wr_hit),
    .idx       (wr_hit_idx),
    .data      (unused_wr_data)
  );

  assign store = wr_valid && !wr_short && !flush;
  assign tgt   = wr_hit ? wr_hit_idx : victim;

  // Lookup side.
  logic [RD_PORTS-1:0]              lk_hit;
  logic [RD_PORTS-1:0][IDX_W-1:0]   lk_idx;
  logic [RD_PORTS-1:0][DATA_W-1:0]  lk_data;

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_port
    logic [ENTRIES-1:0] unused_match;
    rl_read_port #(.N(ENTRIES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_rd (
      .ent_valid (valid_q),
      .ent_tag   (tag_q),
      .ent_data  (data_q),
      .req_tag   (lk_tag[p*TAG_W +: TAG_W]),
      .match     (unused_match),
      .hit       (lk_hit[p]),
      .idx       (lk_idx[p]),
      .data      (lk_data[p])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rsp_valid[p]                <= 1'b0;
        rsp_hit[p]                  <= 1'b0;
        rsp_data[p*DATA_W +: DATA_W] <= '0;
      end else begin
        rsp_valid[p]                <= lk_valid[p];
        rsp_hit[p]                  <= lk_valid[p] && lk_hit[p];
        rsp_data[p*DATA_W +: DATA_W] <= (lk_valid[p] && lk_hit[p]) ? lk_data[p] : '0;
      end
    end
  end

  rl_repl #(.N(ENTRIES), .RD_PORTS(RD_PORTS), .POLICY(POLICY)) u_repl (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .ent_valid (valid_q),
    .rd_en     (lk_valid & lk_hit),
    .rd_idx    (lk_idx),
    .wr_en     (store),
    .wr_idx    (tgt),
    .alloc     (store && !wr_hit),
    .victim    (victim)
  );

  // Entry storage.
  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      valid_q <= '0;
    end else if (store) begin
      valid_q[tgt] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (store) begin
      tag_q[tgt]  <= wr_tag;
      data_q[tgt] <= wr_data;
    end
  end
endmodule

// File: rtl/rl_cache_chk.sv
module rl_cache_chk #(
  parameter int ENTRIES  = 8,
  parameter int TAG_W    = 7,
  parameter int DATA_W   = 32,
  parameter int RD_PORTS = 2
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          flush,
  input logic                          wr_valid,
  input logic                          wr_short,
  input logic [TAG_W-1:0]              wr_tag,
  input logic [RD_PORTS-1:0]           lk_valid,
  input logic [RD_PORTS*TAG_W-1:0]     lk_tag,
  input logic [RD_PORTS-1:0]           rsp_valid,
  input logic [RD_PORTS-1:0]           rsp_hit,
  input logic [RD_PORTS*DATA_W-1:0]    rsp_data,
  input logic [ENTRIES-1:0]            valid_q,
  input logic [ENTRIES-1:0][TAG_W-1:0] tag_q,
  input logic [ENTRIES-1:0]            wr_match
);
  for (genvar p = 0; p < RD_PORTS; p++) begin : g_p
    p_rsp_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid[p] |=> rsp_valid[p]);
    p_no_stray_rsp_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid[p] |=> !rsp_valid[p]);
    p_hit_in_rsp_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit[p] |-> rsp_valid[p]);
    p_miss_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid[p] && !rsp_hit[p]) |-> (rsp_data[p*DATA_W +: DATA_W] == '0));
    p_write_visible_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_short && !flush) ##1
      (lk_valid[p] && lk_tag[p*TAG_W +: TAG_W] == $past(wr_tag)) |=> rsp_hit[p]);
    p_flush_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flush ##1 lk_valid[p] |=> !rsp_hit[p]);
  end

  p_short_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_short && !flush) |=> ($stable(valid_q) && $stable(tag_q)));
  p_unique_tag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_match));
  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0));
endmodule

bind rl_cache rl_cache_chk #(
  .ENTRIES(ENTRIES), .TAG_W(TAG_W), .DATA_W(DATA_W), .RD_PORTS(RD_PORTS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush     (flush),
  .wr_valid  (wr_valid),
  .wr_short  (wr_short),
  .wr_tag    (wr_tag),
  .lk_valid  (lk_valid),
  .lk_tag    (lk_tag),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_data  (rsp_data),
  .valid_q   (valid_q),
  .tag_q     (tag_q),
  .wr_match  (wr_match)
);

// File: tb/rl_cache_bench.sv
module rl_cache_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int TW = 7;
  localparam int DW = 32;
  localparam int RP = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0, wr_valid = 1'b0, wr_short = 1'b0;
  logic [TW-1:0] wr_tag = '0;
  logic [DW-1:0] wr_data = '0;
  logic [RP-1:0] lk_valid = '0;
  logic [RP*TW-1:0] lk_tag = '0;
  logic [RP-1:0] rv0, rh0, rv1, rh1;
  logic [RP*DW-1:0] rd0, rd1;

  always #(CLK_PERIOD/2) clk = ~clk;

  rl_cache #(.ENTRIES(N), .TAG_W(TW), .DATA_W(DW), .RD_PORTS(RP),
             .POLICY(rl_pkg::RL_LRU)) u_rl_cache (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_valid(wr_valid),
    .wr_short(wr_short), .wr_tag(wr_tag), .wr_data(wr_data),
    .lk_valid(lk_valid), .lk_tag(lk_tag),
    .rsp_valid(rv0), .rsp_hit(rh0), .rsp_data(rd0));

  rl_cache #(.ENTRIES(N), .TAG_W(TW), .DATA_W(DW), .RD_PORTS(RP),
             .POLICY(rl_pkg::RL_FIFO)) u_rl_cache_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_valid(wr_valid),
    .wr_short(wr_short), .wr_tag(wr_tag), .wr_data(wr_data),
    .lk_valid(lk_valid), .lk_tag(lk_tag),
    .rsp_valid(rv1), .rsp_hit(rh1), .rsp_data(rd1));

  int compared = 0, mismatched = 0;
  bit done = 1'b0;
  string phase = "R10";

  // Behavioural model: m=0 is the LRU instance, m=1 the FIFO instance.
  bit            mv [2][N];
  logic [TW-1:0] mt [2][N];
  logic [DW-1:0] md [2][N];
  int lru_q[$];   // front = most recently touched
  int fifo_q[$];  // front = allocated longest ago
  bit            ev [2][RP];
  bit            eh [2][RP];
  logic [DW-1:0] ed [2][RP];

  function automatic string req_of(int m);
    if (phase == "EVICT") return (m == 0) ? "R7" : "R6";
    return phase;
  endfunction

  task automatic chk(int m, int p, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s inst%0d port%0d %s: actual %0h expected %0h",
               req_of(m), m, p, what, act, exp);
    end
  endtask

  task automatic compare_all();
    for (int p = 0; p < RP; p++) begin
      chk(0, p, "rsp_valid", DW'(rv0[p]), DW'(ev[0][p]));
      chk(0, p, "rsp_hit",   DW'(rh0[p]), DW'(eh[0][p]));
      chk(0, p, "rsp_data",  rd0[p*DW +: DW], ed[0][p]);
      chk(1, p, "rsp_valid", DW'(rv1[p]), DW'(ev[1][p]));
      chk(1, p, "rsp_hit",   DW'(rh1[p]), DW'(eh[1][p]));
      chk(1, p, "rsp_data",  rd1[p*DW +: DW], ed[1][p]);
    end
  endtask

  task automatic lru_touch(int i);
    for (int k = 0; k < lru_q.size(); k++) begin
      if (lru_q[k] == i) begin
        lru_q.delete(k);
        break;
      end
    end
    lru_q.push_front(i);
  endtask

  function automatic int find(int m, logic [TW-1:0] t);
    for (int i = 0; i < N; i++) if (mv[m][i] && mt[m][i] == t) return i;
    return -1;
  endfunction

  // Advance the model by the coming clock edge with the inputs now driven.
  task automatic step(int m);
    int hit_idx[RP];
    int victim, wi, first_free;
    for (int p = 0; p < RP; p++) begin
      hit_idx[p] = find(m, lk_tag[p*TW +: TW]);
      ev[m][p] = lk_valid[p];
      eh[m][p] = lk_valid[p] && hit_idx[p] >= 0;
      ed[m][p] = eh[m][p] ? md[m][hit_idx[p]] : '0;
    end
    first_free = -1;
    for (int i = N - 1; i >= 0; i--) if (!mv[m][i]) first_free = i;
    if (first_free >= 0) victim = first_free;
    else victim = (m == 0) ? lru_q[$] : fifo_q[0];
    if (m == 0) begin
      for (int p = 0; p < RP; p++) if (eh[m][p]) lru_touch(hit_idx[p]);
    end
    if (wr_valid && !wr_short && !flush) begin
      wi = find(m, wr_tag);
      if (wi < 0) begin
        wi = victim;
        if (m == 1) begin
          if (first_free < 0) void'(fifo_q.pop_front());
          fifo_q.push_back(wi);
        end
      end
      if (m == 0) lru_touch(wi);
      mv[m][wi] = 1'b1;
      mt[m][wi] = wr_tag;
      md[m][wi] = wr_data;
    end
    if (flush) begin
      for (int i = 0; i < N; i++) mv[m][i] = 1'b0;
      if (m == 1) fifo_q.delete();
    end
  endtask

  // One cycle: check responses, drive new inputs, advance the model.
  task automatic cyc(int pw, int ps, int tlo, int thi, int pl, int pf);
    @(negedge clk);
    compare_all();
    wr_valid = ($urandom_range(99) < pw);
    wr_short = ($urandom_range(99) < ps);
    wr_tag   = TW'($urandom_range(thi, tlo));
    wr_data  = $urandom;
    flush    = ($urandom_range(99) < pf);
    for (int p = 0; p < RP; p++) begin
      lk_valid[p] = ($urandom_range(99) < pl);
      lk_tag[p*TW +: TW] = TW'($urandom_range(thi, tlo));
    end
    step(0);
    step(1);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    mismatched++;
    $display("FAIL watchdog expired: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      lru_q.push_back(i);
      mv[0][i] = 1'b0;
      mv[1][i] = 1'b0;
    end
    for (int m = 0; m < 2; m++)
      for (int p = 0; p < RP; p++) begin
        ev[m][p] = 1'b0; eh[m][p] = 1'b0; ed[m][p] = '0;
      end
    // R10: outputs quiet during and right after reset.
    phase = "R10";
    repeat (3) begin
      @(negedge clk);
      compare_all();
    end
    rst_n = 1'b1;
    repeat (2) cyc(0, 0, 0, 5, 0, 0);
    // R3: fill with long-lived results while probing.
    phase = "R3";
    repeat (12) cyc(100, 0, 0, 5, 60, 0);
    // R1: lookups of stored tags only.
    phase = "R1";
    repeat (12) cyc(0, 0, 0, 5, 100, 0);
    // R2: tags never written.
    phase = "R2";
    repeat (10) cyc(0, 0, 40, 47, 100, 0);
    // R4: short-lived writes, then probe them.
    phase = "R4";
    repeat (12) cyc(100, 100, 20, 30, 100, 0);
    repeat (6) cyc(0, 0, 20, 30, 100, 0);
    // R5: rewrite stored tags with fresh data.
    phase = "R5";
    repeat (16) cyc(100, 0, 0, 5, 100, 0);
    // R6 / R7: more tags than entries forces replacement.
    phase = "EVICT";
    repeat (120) cyc(70, 0, 0, 15, 80, 0);
    // R8: occasional flushes.
    phase = "R8";
    repeat (80) cyc(70, 10, 0, 12, 80, 12);
    // R9: both ports, all kinds of traffic.
    phase = "R9";
    repeat (3000) cyc(60, 30, 0, 14, 90, 2);
    @(negedge clk);
    compare_all();
    summary();
    $finish;
  end
endmodule